// File: doc/BRIEF.md
# Multi-Port Power Sharing Arbiter

This block sits on the master port of a multi-port USB charger. It divides one fixed total power budget among up to eight ports. Port 0 is the master and ports 1 and up are slaves. Each time an attach or detach interrupt strobe arrives, the block samples which ports have a device attached, masks them with an enable vector, and latches the configured total budget. The budget is usually 65 W, 100 W or 140 W.

It then runs through the ports in priority order, one port per clock cycle. For each port it writes a new allowance in watts. A port whose allowance changed gets an update flag, which tells the transport logic to send that port a new offer. When the pass finishes, the block pulses done. A strobe that arrives during a pass is remembered, and a second pass runs straight after the first, so no attach or detach event is lost.

Top module: `pwr_share_arb`

## Requirements
- R1: After reset, every allowance is 0 W, and upd, busy and done are all low.
- R2: A strobe sampled on an idle clock edge latches (attach & port_en) and total_w, and busy goes high. done is high for exactly one cycle after the N-th following edge, and at that point busy falls unless another pass is queued.
- R3: If exactly one enabled port is attached, that port is granted the whole latched total, whatever its number, even when the total is above PORT_MAX.
- R4: With two or more ports active, the master port 0 (if active) is served first and receives min(PORT_MAX, total).
- R5: Active slave ports are served in ascending port number. Each one receives min(PORT_MAX, remaining budget) while the remaining budget is at least FLOOR (15 W), and the remaining budget is reduced by that grant.
- R6: A port served while the remaining budget is above 0 but below FLOOR receives FLOOR, and the remaining budget becomes 0. A port served after the budget reaches 0 receives 0 W.
- R7: A port that is unattached, or whose port_en bit is 0, is allocated 0 W.
- R8: upd[i] is cleared when a pass starts and set if port i's new allowance differs from its previous one. It is valid from done until the next pass starts.
- R9: A strobe sampled while a pass is running queues exactly one further pass. That pass starts on the edge where the current pass ends and samples the inputs at that edge.
- R10: Allowances change only during a pass. While the block is idle, changes on attach, port_en or total_w have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt | input | 1 | Attach/detach interrupt strobe |
| attach | input | N | Per-port device-attached status |
| port_en | input | N | Per-port enable mask |
| total_w | input | PW | Total system budget in watts |
| alloc | output | N*PW | Allowances; port i at bits [i*PW +: PW] |
| upd | output | N | Per-port allowance-changed flags |
| busy | output | 1 | Allocation pass in progress |
| done | output | 1 | One-cycle pass-complete pulse |

## Verification
Some properties are checked on every cycle by assertions:
- done lasts a single cycle;
- no pass runs longer than N cycles;
- allowances hold still while the block is idle;
- at the end of a pass, a port that was not latched as active holds 0 W;
- a lone active port holds the latched total.

The priority arithmetic needs known input patterns, so only the bench's directed scenarios show it: the master-first cap, the slave order, the floor grant into a short remaining budget, and the zero grant after the budget runs out. The bench scenarios also cover the correctness of the update flags and the queued pass that follows a strobe arriving mid-pass.

// File: rtl/pwr_share_arb.sv
module pwr_share_arb #(
  parameter int N        = 8,
  parameter int PW       = 8,
  parameter int PORT_MAX = 100,
  parameter int FLOOR    = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evt,
  input  logic [N-1:0]    attach,
  input  logic [N-1:0]    port_en,
  input  logic [PW-1:0]   total_w,
  output logic [N*PW-1:0] alloc,
  output logic [N-1:0]    upd,
  output logic            busy,
  output logic            done
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [PW-1:0] MAXW = PW'(PORT_MAX);
  localparam logic [PW-1:0] FLW  = PW'(FLOOR);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [N-1:0]  eff_q, upd_q;
  logic [PW-1:0] tot_q, rem_q;
  logic [IW-1:0] idx_q;
  logic          lone_q, busy_q, done_q, pend_q;
  logic [PW-1:0] alloc_q [N];

  logic [N-1:0]  eff_in;
  logic          last, start;
  logic [PW-1:0] cap, grant, rem_nx;

  assign eff_in = attach & port_en;
  assign last   = busy_q && (idx_q == LAST);
  assign start  = busy_q ? (last && (pend_q || evt)) : evt;
  assign cap    = (rem_q < MAXW) ? rem_q : MAXW;

  always_comb begin
    if (!eff_q[idx_q])      grant = '0;
    else if (lone_q)        grant = tot_q;
    else if (rem_q >= FLW)  grant = cap;
    else if (rem_q != '0)   grant = FLW;
    else                    grant = '0;
  end

  assign rem_nx = (eff_q[idx_q] && !lone_q) ? ((grant >= rem_q) ? '0 : rem_q - grant) : rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_q  <= '0;
      upd_q  <= '0;
      tot_q  <= '0;
      rem_q  <= '0;
      idx_q  <= '0;
      lone_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pend_q <= 1'b0;
      for (int i = 0; i < N; i++) alloc_q[i] <= '0;
    end else begin
      done_q <= last;
      if (busy_q) begin
        alloc_q[idx_q] <= grant;
        upd_q[idx_q]   <= (grant != alloc_q[idx_q]);
        rem_q          <= rem_nx;
        idx_q          <= idx_q + 1'b1;
        if (evt && !last) pend_q <= 1'b1;
        if (last) busy_q <= 1'b0;
      end
      if (start) begin
        eff_q  <= eff_in;
        tot_q  <= total_w;
        rem_q  <= total_w;
        lone_q <= ($countones(eff_in) == 1);
        idx_q  <= '0;
        busy_q <= 1'b1;
        pend_q <= 1'b0;
        upd_q  <= '0;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_out
    assign alloc[g*PW +: PW] = alloc_q[g];
  end

  assign upd  = upd_q;
  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/pwr_share_arb_chk.sv
module pwr_share_arb_chk #(
  parameter int N  = 8,
  parameter int PW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic [N-1:0]    eff,
  input logic [PW-1:0]   tot,
  input logic [N*PW-1:0] alloc
);
  logic [7:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               run_cnt <= '0;
    else if (!busy || done)   run_cnt <= '0;
    else                      run_cnt <= run_cnt + 1'b1;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2

  AST_PASS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt <= 8'(N))); // R2

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(alloc)); // R10

  for (genvar g = 0; g < N; g++) begin : g_port
    AST_INACTIVE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !busy && !eff[g]) |-> (alloc[g*PW +: PW] == '0)); // R7

    AST_LONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !busy && eff[g] && $countones(eff) == 1) |-> (alloc[g*PW +: PW] == tot)); // R3
  end
endmodule

bind pwr_share_arb pwr_share_arb_chk #(.N(N), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .eff(eff_q), .tot(tot_q), .alloc(alloc)
);

// File: tb/pwr_share_arb_bench.sv
`timescale 1ns/1ps
module pwr_share_arb_bench;
  localparam int N = 8, PW = 8, PMAX = 100, FL = 15;

  logic clk = 0, rst_n = 0, evt = 0;
  logic [N-1:0] attach = '0, port_en = '1;
  logic [PW-1:0] total_w = '0;
  logic [N*PW-1:0] alloc;
  logic [N-1:0] upd;
  logic busy, done;
  int checks = 0, failures = 0, cyc = 0;
  logic [N*PW-1:0] prev_exp = '0;

  always #2.5 clk = ~clk;

  pwr_share_arb #(.N(N), .PW(PW), .PORT_MAX(PMAX), .FLOOR(FL)) u_pwr_share_arb (
    .clk(clk), .rst_n(rst_n), .evt(evt), .attach(attach), .port_en(port_en),
    .total_w(total_w), .alloc(alloc), .upd(upd), .busy(busy), .done(done));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [N*PW-1:0] model(input logic [N-1:0] at, input logic [N-1:0] en, input int tot);
    logic [N*PW-1:0] r = '0;
    logic [N-1:0] act = at & en;
    int rem = tot, g;
    for (int i = 0; i < N; i++) begin
      g = 0;
      if (act[i]) begin
        if ($countones(act) == 1) g = tot;
        else if (rem >= FL) g = (rem < PMAX) ? rem : PMAX;
        else if (rem > 0) g = FL;
        rem = (g >= rem) ? 0 : rem - g;
      end
      r[i*PW +: PW] = PW'(g);
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk); evt = 1;
    @(negedge clk); evt = 0;
  endtask

  task automatic wait_done(output int n);
    n = 1;
    while (!done) begin @(negedge clk); n++; end
  endtask

  task automatic check_result(input string req, input logic [N*PW-1:0] exp);
    logic [N-1:0] u;
    for (int i = 0; i < N; i++) u[i] = (exp[i*PW +: PW] != prev_exp[i*PW +: PW]);
    chk(req, 64'(alloc), 64'(exp));
    chk({req, "/R8 upd"}, 64'(upd), 64'(u));
    prev_exp = exp;
  endtask

  task automatic run_case(input string req, input logic [N-1:0] at, input logic [N-1:0] en, input int tot);
    int n;
    attach = at; port_en = en; total_w = PW'(tot);
    strobe();
    wait_done(n);
    chk("R2 done latency", 64'(n), 64'(N + 1));
    check_result(req, model(at, en, tot));
    @(negedge clk);
    chk("R2 done single cycle", 64'(done), 64'(0));
    chk("R2 busy low", 64'(busy), 64'(0));
  endtask

  task automatic t_reset();
    chk("R1 alloc", 64'(alloc), 64'(0));
    chk("R1 upd", 64'(upd), 64'(0));
    chk("R1 busy", 64'(busy), 64'(0));
    chk("R1 done", 64'(done), 64'(0));
  endtask

  task automatic t_idle_ignore();
    logic [N*PW-1:0] keep = alloc;
    attach = 8'hFF; total_w = 8'd7;
    repeat (5) @(negedge clk);
    chk("R10 idle input change", 64'(alloc), 64'(keep));
  endtask

  task automatic t_queued();
    int n;
    attach = 8'h01; port_en = 8'hFF; total_w = 8'd140;
    strobe();
    @(negedge clk); attach = 8'h0E; total_w = 8'd65; evt = 1;
    @(negedge clk); evt = 0;
    wait_done(n);
    prev_exp = model(8'h01, 8'hFF, 140);
    @(negedge clk);
    chk("R9 busy after first pass", 64'(busy), 64'(1));
    wait_done(n);
    check_result("R9 queued pass", model(8'h0E, 8'hFF, 65));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    run_case("R3 lone slave gets total", 8'h20, 8'hFF, 140);
    run_case("R4/R5 master then slave", 8'h05, 8'hFF, 140);
    run_case("R6 floor then zero", 8'h07, 8'hFF, 110);
    run_case("R5 slave order", 8'h46, 8'hFF, 140);
    run_case("R6 budget exhausted", 8'h0B, 8'hFF, 65);
    run_case("R7 disabled ports zero", 8'h32, 8'h0F, 100);
    run_case("R8 repeat no change", 8'h32, 8'h0F, 100);
    run_case("R4 master alone capped by lone", 8'h01, 8'hFF, 65);
    t_idle_ignore();
    t_queued();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule